// File: doc/BRIEF.md
# Sample FIFO Audio Channel

This block is one voice of a sampled-audio source. Software loads unsigned 8-bit samples into a 256-entry first-in first-out store, one byte per data write. A 12-bit period timer sets how long each sample stays on the output. A 4-bit volume scales the sample's distance from the silent midpoint (0x80) before it reaches the output.

Playback needs no start command. The first byte pushed into an empty store starts the voice at once. The voice goes quiet again as soon as the store runs dry. Period writes are held in a pending register and reach the running timer only when the current sample ends. A separate strobe flushes the store and silences the voice at any time. A status byte reports whether the store is full or empty. Address decoding and the mixing of several voices are left to the surrounding logic.

Top module: `pcm_voice`

## Requirements
- R1: After reset the status byte reads 0x40 (empty flag only), the output reads 0x80, the volume is 15 and the pending period is 0.
- R2: A cycle with `sample_we` high and the store not full pushes `wdata` into the store. On the following cycle the empty flag (status bit 6) is clear, and the output shows the scaled first byte.
- R3: The store holds 256 bytes. With 256 bytes held, status reads 0x80 (bit 7 = full, all other bits zero). A push into a full store is dropped and never reaches the output.
- R4: With period P, each sample stays on the output for P+1 cycles, and samples play in the order they were pushed.
- R5: While the store is empty the output is 0x80 and the status reads 0x40. The voice goes silent in the cycle after the last sample's time runs out.
- R6: A period written during playback does not change how long the current sample lasts. It sets the length of the next sample.
- R7: The period is {period-high `wdata[3:0]`, period-low `wdata[7:0]`}, taken from the writes on `period_hi_we` and `period_lo_we`. The volume is `wdata[7:4]` of the period-high write and applies at once.
- R8: While the voice is playing, the output is 128 + trunc((s-128)*v/15), where s is the current sample, v is the volume, and the division truncates toward zero. A volume of 15 passes the sample unchanged, and a volume of 0 gives 0x80.
- R9: A cycle with `clear_we` high empties the store and silences the voice on the next cycle. A push in the same cycle is discarded.
- R10: When a push and a sample-end pop fall in the same cycle, both take effect: the store's fill level is unchanged and the pushed byte follows in order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the timer counts once per cycle |
| rst | input | 1 | Synchronous active-high reset |
| clear_we | input | 1 | Flush strobe; empties the store |
| sample_we | input | 1 | Push strobe for `wdata` |
| period_lo_we | input | 1 | Loads the low 8 bits of the pending period |
| period_hi_we | input | 1 | Loads the high 4 period bits and the volume |
| wdata | input | 8 | Write data shared by all strobes |
| status | output | 8 | Bit 7 full, bit 6 empty, other bits zero |
| audio_out | output | 8 | Scaled unsigned sample, 0x80 when silent |

## Verification
The assertions assume that the strobes are stable, known values at every rising edge once reset is released. They also assume that at most one period or flush strobe is meaningful in any cycle. The bench drives each strobe for exactly one cycle from the falling edge, and only combines a flush with a push when it is testing that the flush takes priority. Period and volume are always written before the push that starts playback, so the countdown length is known when each check runs.

// File: rtl/pcm_voice_pkg.sv
package pcm_voice_pkg;

    localparam int SAMPLE_W   = 8;
    localparam int PERIOD_W   = 12;
    localparam int VOL_W      = 4;
    localparam int FIFO_DEPTH = 256;
    localparam logic [SAMPLE_W-1:0] MIDPOINT = 8'h80;
    localparam logic [VOL_W-1:0]    VOL_MAX  = 4'hF;

    typedef struct packed {
        logic       full;
        logic       empty;
        logic [5:0] pad;
    } voice_status_t;

    typedef struct packed {
        logic [PERIOD_W-1:0] period;
        logic [VOL_W-1:0]    vol;
    } voice_cfg_t;

    // Scale the signed distance from the midpoint by vol/15, truncating toward zero.
    function automatic logic [SAMPLE_W-1:0] scale_sample(
        input logic [SAMPLE_W-1:0] s,
        input logic [VOL_W-1:0]    v
    );
        logic signed [13:0] off;
        logic signed [13:0] gain;
        logic signed [13:0] prod;
        logic signed [13:0] quo;
        logic signed [13:0] res;
        off  = $signed({6'd0, s}) - 14'sd128;
        gain = $signed({10'd0, v});
        prod = off * gain;
        quo  = prod / 14'sd15;
        res  = quo + 14'sd128;
        return res[SAMPLE_W-1:0];
    endfunction

endpackage

// File: rtl/pcm_fifo.sv
module pcm_fifo #(
    parameter int DEPTH = 256,
    parameter int DW    = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          flush,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head,
    output logic          empty,
    output logic          full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL_LEVEL = CW'(DEPTH);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr, wr_nxt, rd_nxt;
    logic [CW-1:0] level;
    logic          do_push, do_pop;

    assign empty   = (level == '0);
    assign full    = (level == FULL_LEVEL);
    assign do_push = push && !full && !flush;
    assign do_pop  = pop && !empty && !flush;
    assign head    = mem[rd_ptr];

    // Pointer advance: free wrap when the depth is a power of two.
    generate
        if ((1 << AW) == DEPTH) begin : g_pow2
            assign wr_nxt = wr_ptr + 1'b1;
            assign rd_nxt = rd_ptr + 1'b1;
        end else begin : g_mod
            assign wr_nxt = (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            assign rd_nxt = (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (do_push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_nxt;
            if (do_pop)  rd_ptr <= rd_nxt;
            case ({do_push, do_pop})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end

    p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
        level <= FULL_LEVEL);

    p_full_push_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop && !flush) |=> full);

    p_push_leaves_empty_r2: assert property (@(posedge clk) disable iff (rst)
        (push && !flush) |=> !empty);

    p_flush_empties_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> empty);

endmodule

// File: rtl/pcm_pacer.sv
module pcm_pacer #(
    parameter int PW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          run,
    input  logic [PW-1:0] reload_val,
    output logic          tick
);
    logic [PW-1:0] remain;

    assign tick = run && (remain == '0);

    // While idle the counter tracks the pending period; once running it only
    // reloads at a sample boundary.
    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (!run || remain == '0) begin
            remain <= reload_val;
        end else begin
            remain <= remain - 1'b1;
        end
    end

    p_mid_sample_hold_r6: assert property (@(posedge clk) disable iff (rst)
        (run && remain != '0 && !$stable(reload_val)) |=> (remain == $past(remain) - 1'b1) || !run);

endmodule

// File: rtl/pcm_scaler.sv
module pcm_scaler
    import pcm_voice_pkg::*;
(
    input  logic                active,
    input  logic [SAMPLE_W-1:0] sample,
    input  logic [VOL_W-1:0]    vol,
    output logic [SAMPLE_W-1:0] level
);
    always_comb begin
        if (!active) begin
            level = MIDPOINT;
        end else if (vol == VOL_MAX) begin
            level = sample;
        end else begin
            level = scale_sample(sample, vol);
        end
    end
endmodule

// File: rtl/pcm_voice.sv
module pcm_voice
    import pcm_voice_pkg::*;
#(
    parameter int DEPTH = FIFO_DEPTH
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       clear_we,
    input  logic       sample_we,
    input  logic       period_lo_we,
    input  logic       period_hi_we,
    input  logic [7:0] wdata,
    output logic [7:0] status,
    output logic [7:0] audio_out
);
    voice_cfg_t          cfg_q;
    voice_status_t       st;
    logic [SAMPLE_W-1:0] head;
    logic                empty, full, pop;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q.period <= '0;
            cfg_q.vol    <= VOL_MAX;
        end else begin
            if (period_lo_we) begin
                cfg_q.period[7:0] <= wdata;
            end
            if (period_hi_we) begin
                cfg_q.period[PERIOD_W-1:8] <= wdata[PERIOD_W-9:0];
                cfg_q.vol                  <= wdata[7:8-VOL_W];
            end
        end
    end

    pcm_fifo #(
        .DEPTH (DEPTH),
        .DW    (SAMPLE_W)
    ) u_store (
        .clk       (clk),
        .rst       (rst),
        .flush     (clear_we),
        .push      (sample_we),
        .push_data (wdata),
        .pop       (pop),
        .head      (head),
        .empty     (empty),
        .full      (full)
    );

    pcm_pacer #(
        .PW (PERIOD_W)
    ) u_pacer (
        .clk        (clk),
        .rst        (rst),
        .run        (!empty),
        .reload_val (cfg_q.period),
        .tick       (pop)
    );

    pcm_scaler u_scale (
        .active (!empty),
        .sample (head),
        .vol    (cfg_q.vol),
        .level  (audio_out)
    );

    assign st     = '{full: full, empty: empty, pad: '0};
    assign status = st;

    p_silent_when_empty_r5: assert property (@(posedge clk) disable iff (rst)
        status[6] |-> (audio_out == MIDPOINT));

    p_pop_nonempty_r4: assert property (@(posedge clk) disable iff (rst)
        pop |-> !status[6]);

    p_vol_zero_mid_r8: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.vol == '0) |-> (audio_out == MIDPOINT));

    p_status_pad_zero_r3: assert property (@(posedge clk) disable iff (rst)
        status[5:0] == 6'd0);

endmodule

// File: tb/pcm_voice_test.sv
module pcm_voice_test;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       clear_we = 1'b0, sample_we = 1'b0, period_lo_we = 1'b0, period_hi_we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] status, audio_out;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    pcm_voice uut (
        .clk          (clk),
        .rst          (rst),
        .clear_we     (clear_we),
        .sample_we    (sample_we),
        .period_lo_we (period_lo_we),
        .period_hi_we (period_hi_we),
        .wdata        (wdata),
        .status       (status),
        .audio_out    (audio_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // {sample, volume} pairs for the scaling walk
    localparam logic [11:0] VEC [0:7] = '{
        12'h00F, 12'hFFF, 12'h007, 12'hFF7,
        12'h400, 12'hC03, 12'h80A, 12'h7F1
    };

    function automatic logic [7:0] ref_scale(input int s, input int v);
        int q;
        q = ((s - 128) * v) / 15;
        return 8'(q + 128);
    endfunction

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual 0x%02h expected 0x%02h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic drive(input logic c, input logic s, input logic l, input logic h, input logic [7:0] d);
        clear_we = c; sample_we = s; period_lo_we = l; period_hi_we = h; wdata = d;
        @(negedge clk);
        clear_we = 1'b0; sample_we = 1'b0; period_lo_we = 1'b0; period_hi_we = 1'b0;
    endtask

    task automatic push(input logic [7:0] d);
        drive(1'b0, 1'b1, 1'b0, 1'b0, d);
    endtask

    task automatic flush();
        drive(1'b1, 1'b0, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic setp(input logic [11:0] p, input logic [3:0] v);
        drive(1'b0, 1'b0, 1'b1, 1'b0, p[7:0]);
        drive(1'b0, 1'b0, 1'b0, 1'b1, {v, p[11:8]});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int polls;
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 status", status, 8'h40);
        check("R1 output", audio_out, 8'h80);
        rst = 1'b0;
        step();

        // R8 table walk: long period so the sample stays put
        setp(12'h0FF, 4'hF);
        for (int i = 0; i < 8; i++) begin
            flush();
            drive(1'b0, 1'b0, 1'b0, 1'b1, {VEC[i][3:0], 4'h0});
            push(VEC[i][11:4]);
            check("R8 scaled", audio_out, ref_scale(int'(VEC[i][11:4]), int'(VEC[i][3:0])));
        end

        // R2 / R4 / R5 pacing and order, period 3
        flush();
        setp(12'd3, 4'hF);
        push(8'h10);
        check("R2 empty flag clear", status, 8'h00);
        push(8'h20);
        push(8'h30);
        for (int k = 2; k <= 13; k++) begin
            check("R4 sample order", audio_out,
                  (k < 4) ? 8'h10 : (k < 8) ? 8'h20 : (k < 12) ? 8'h30 : 8'h80);
            if (k == 13) check("R5 empty status", status, 8'h40);
            step();
        end

        // R6 period change mid-sample
        flush();
        setp(12'd3, 4'hF);
        push(8'hA0);
        push(8'hB0);
        drive(1'b0, 1'b0, 1'b1, 1'b0, 8'd7);
        for (int k = 2; k <= 12; k++) begin
            check("R6 boundary reload", audio_out,
                  (k < 4) ? 8'hA0 : (k < 12) ? 8'hB0 : 8'h80);
            step();
        end

        // R10 push and pop in the same cycle, period 0
        flush();
        setp(12'd0, 4'hF);
        push(8'h11);
        check("R10 first", audio_out, 8'h11);
        push(8'h22);
        check("R10 second", audio_out, 8'h22);
        check("R10 not empty", status, 8'h00);
        push(8'h33);
        check("R10 third", audio_out, 8'h33);
        step();
        check("R10 drained", audio_out, 8'h80);

        // R9 flush wins over a simultaneous push
        flush();
        setp(12'hFFF, 4'hF);
        push(8'h90);
        check("R9 playing", audio_out, 8'h90);
        drive(1'b1, 1'b1, 1'b0, 1'b0, 8'h44);
        check("R9 status", status, 8'h40);
        check("R9 output", audio_out, 8'h80);
        repeat (3) step();
        check("R9 stays silent", audio_out, 8'h80);

        // R7 period assembly and volume field
        flush();
        drive(1'b0, 1'b0, 1'b1, 1'b0, 8'h02);
        drive(1'b0, 1'b0, 1'b0, 1'b1, 8'h81);
        push(8'hFF);
        check("R7 volume 8", audio_out, ref_scale(255, 8));
        repeat (258) step();
        check("R7 last cycle of 0x102", audio_out, ref_scale(255, 8));
        step();
        check("R7 ends after 259", audio_out, 8'h80);

        // R3 fill to depth, drop the extra push, then drain
        flush();
        setp(12'hFFF, 4'hF);
        for (int i = 0; i < 256; i++) push(8'(i));
        check("R3 full status", status, 8'h80);
        push(8'h55);
        check("R3 full after extra", status, 8'h80);
        setp(12'd0, 4'hF);
        polls = 0;
        while (audio_out == 8'h00 && polls < 5000) begin
            step();
            polls++;
        end
        check("R3 second sample", audio_out, 8'h01);
        for (int j = 2; j < 256; j++) begin
            step();
            check("R3 drain order", audio_out, 8'(j));
        end
        step();
        check("R3 extra push dropped", audio_out, 8'h80);
        check("R3 empty at end", status, 8'h40);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule